// File: doc/BRIEF.md
# Committed Store Coalescing Queue

This block sits behind the commit point of a load/store pipeline. It takes stores only after they have been committed. Each store goes into a small circular queue. An entry holds a doubleword tag, a 64-bit data lane and per-byte enables. A new store whose doubleword matches an entry that is still open is folded into that entry byte by byte, so it does not use a new slot. Each entry then leaves the queue as a single downstream transaction.

Only the oldest entry may issue. It raises exactly one of three requests: a write into the data cache RAM, a linefill request to the bus unit, or a write on the external AXI master. The route is fixed when the entry is allocated. It is derived from the allocating store's cacheability, hit and write-allocate attributes. A grant on the active path retires the head. A drain input closes every open entry, and a status output reports when the queue is empty.

Top module: `stb_merge_buf`

## Requirements
- R1: After reset the queue is empty: `drained` is 1, `st_ready` is 1, and no request output is high.
- R2: A store is taken only in a cycle where `st_valid` and `st_ready` are both high. With `st_valid` low, no entry is created or altered, whatever the other store inputs carry.
- R3: A store to doubleword `st_addr[31:3]` that matches an open entry merges into it. Each byte lane with `st_be[k]=1` replaces data bits [8k+7:8k], the byte enables are ORed together, and the entry keeps the route of its first store. The result is one transaction.
- R4: An entry whose first store had `st_cacheable=1` and `st_hit=1` issues on `ram_req`.
- R5: An entry whose first store had `st_cacheable=1`, `st_hit=0` and `st_wr_alloc=1` issues on `lf_req`.
- R6: Every other entry issues on `axi_req`.
- R7: Entries issue strictly in allocation order. Only the head may request, and at most one of the three request outputs is high at a time.
- R8: A request stays high with unchanged `out_addr` until its own grant input is sampled high. The grant retires the head entry.
- R9: When all DEPTH entries are occupied and the store matches no open entry, `st_ready` is 0. A store that matches an open entry is still accepted.
- R10: A `drain` pulse closes all entries. A later store to the same doubleword allocates a fresh entry and gives a separate transaction. The head being granted in the current cycle also takes no merge.
- R11: `drained` is 1 exactly when the queue holds no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Committed store present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | AW | Store byte address (low 3 bits ignored) |
| st_data | input | DW | Store data placed in its doubleword lanes |
| st_be | input | DW/8 | Byte enables for the store |
| st_cacheable | input | 1 | Store targets cacheable memory |
| st_wr_alloc | input | 1 | Write-allocate policy for the store |
| st_hit | input | 1 | Data cache hit for the store's line |
| drain | input | 1 | Close all open entries |
| drained | output | 1 | Queue is empty |
| ram_req | output | 1 | Head requests a cache RAM write |
| ram_gnt | input | 1 | Cache RAM write accepted |
| lf_req | output | 1 | Head requests a linefill |
| lf_gnt | input | 1 | Linefill request accepted |
| axi_req | output | 1 | Head requests an external bus write |
| axi_gnt | input | 1 | External write accepted |
| out_addr | output | AW-3 | Doubleword address of the head |
| out_data | output | DW | Merged data of the head |
| out_be | output | DW/8 | Merged byte enables of the head |

## Verification
The bench builds the block with its defaults: four entries, 32-bit addresses, a 64-bit data lane and the linefill route enabled. With only four slots, a handful of distinct doublewords fills the queue. That brings the stall on a full queue and the still-accepted merge into a full queue within reach. A scattered address set over six doublewords, with randomly withheld grants, makes merges land on a head whose grant arrives in the same cycle.

// File: rtl/stb_pkg.sv
`timescale 1ns/1ps
package stb_pkg;
   typedef enum logic [1:0] {
      RT_RAM      = 2'd0,
      RT_LINEFILL = 2'd1,
      RT_AXI      = 2'd2
   } stb_route_e;
endpackage

// File: rtl/stb_route_sel.sv
`timescale 1ns/1ps
module stb_route_sel
   import stb_pkg::*;
#(
   parameter bit LINEFILL_EN = 1'b1
) (
   input  logic       cacheable,
   input  logic       wr_alloc,
   input  logic       hit,
   output stb_route_e route
);
   generate
      if (LINEFILL_EN) begin : g_with_lf
         always_comb begin
            if (cacheable && hit)                route = RT_RAM;
            else if (cacheable && wr_alloc)      route = RT_LINEFILL;
            else                                 route = RT_AXI;
         end
      end else begin : g_no_lf
         logic unused_wa;
         assign unused_wa = wr_alloc;
         always_comb begin
            if (cacheable && hit) route = RT_RAM;
            else                  route = RT_AXI;
         end
      end
   endgenerate
endmodule

// File: rtl/stb_match.sv
`timescale 1ns/1ps
module stb_match #(
   parameter int DEPTH = 4,
   parameter int TW    = 29,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TW-1:0]     tag_i,
   input  logic [TW-1:0]     ent_tag_i [DEPTH],
   input  logic [DEPTH-1:0]  open_i,
   output logic              hit_o,
   output logic [PW-1:0]     idx_o,
   output logic [DEPTH-1:0]  vec_o
);
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
         assign vec_o[g] = open_i[g] && (ent_tag_i[g] == tag_i);
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (vec_o[i]) idx_o = idx_o | PW'(i);
      end
   end

   assign hit_o = |vec_o;

   // at most one open entry per doubleword (R3)
   p_single_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(vec_o));
endmodule

// File: rtl/stb_byte_merge.sv
`timescale 1ns/1ps
module stb_byte_merge #(
   parameter int BW = 8,
   localparam int DW = BW * 8
) (
   input  logic [DW-1:0] old_data,
   input  logic [DW-1:0] new_data,
   input  logic [BW-1:0] new_be,
   output logic [DW-1:0] merged
);
   generate
      for (genvar b = 0; b < BW; b++) begin : g_lane
         assign merged[8*b +: 8] = new_be[b] ? new_data[8*b +: 8] : old_data[8*b +: 8];
      end
   endgenerate
endmodule

// File: rtl/stb_merge_buf.sv
`timescale 1ns/1ps
module stb_merge_buf
   import stb_pkg::*;
#(
   parameter int AW          = 32,
   parameter int DW          = 64,
   parameter int DEPTH       = 4,
   parameter bit LINEFILL_EN = 1'b1,
   localparam int BW         = DW / 8,
   localparam int OW         = $clog2(BW),
   localparam int TW         = AW - OW,
   localparam int PW         = $clog2(DEPTH),
   localparam int CW         = PW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          st_valid,
   output logic          st_ready,
   input  logic [AW-1:0] st_addr,
   input  logic [DW-1:0] st_data,
   input  logic [BW-1:0] st_be,
   input  logic          st_cacheable,
   input  logic          st_wr_alloc,
   input  logic          st_hit,
   input  logic          drain,
   output logic          drained,
   output logic          ram_req,
   input  logic          ram_gnt,
   output logic          lf_req,
   input  logic          lf_gnt,
   output logic          axi_req,
   input  logic          axi_gnt,
   output logic [TW-1:0] out_addr,
   output logic [DW-1:0] out_data,
   output logic [BW-1:0] out_be
);
   // elaboration checks
   generate
      if (DW % 8 != 0 || BW != (1 << OW)) begin : g_bad_dw
         $error("DW must be a power-of-two multiple of 8");
      end
      if (DEPTH < 2 || DEPTH != (1 << PW)) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (AW <= OW) begin : g_bad_aw
         $error("AW too small for the data lane");
      end
   endgenerate

   // storage
   logic [DEPTH-1:0] valid_q, open_q;
   logic [TW-1:0]    tag_q   [DEPTH];
   logic [DW-1:0]    data_q  [DEPTH];
   logic [BW-1:0]    be_q    [DEPTH];
   stb_route_e       route_q [DEPTH];
   logic [PW-1:0]    head_q, tail_q;
   logic [CW-1:0]    count_q;

   // head view
   logic       head_v;
   stb_route_e head_rt;
   logic       fire, full;

   assign head_v   = valid_q[head_q];
   assign head_rt  = route_q[head_q];
   assign ram_req  = head_v && (head_rt == RT_RAM);
   assign lf_req   = head_v && (head_rt == RT_LINEFILL);
   assign axi_req  = head_v && (head_rt == RT_AXI);
   assign out_addr = tag_q[head_q];
   assign out_data = data_q[head_q];
   assign out_be   = be_q[head_q];
   assign fire     = (ram_req && ram_gnt) || (lf_req && lf_gnt) || (axi_req && axi_gnt);
   assign full     = (count_q == CW'(DEPTH));
   assign drained  = (count_q == '0);

   // merge window: open entries, minus the head leaving now, none while draining
   logic [DEPTH-1:0] open_eff;
   always_comb begin
      open_eff = open_q;
      if (fire) open_eff[head_q] = 1'b0;
      if (drain) open_eff = '0;
   end

   logic [TW-1:0]    st_tag;
   logic             m_hit;
   logic [PW-1:0]    m_idx;
   logic [DEPTH-1:0] m_vec;
   assign st_tag = st_addr[AW-1:OW];

   stb_match #(.DEPTH(DEPTH), .TW(TW)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .tag_i    (st_tag),
      .ent_tag_i(tag_q),
      .open_i   (open_eff),
      .hit_o    (m_hit),
      .idx_o    (m_idx),
      .vec_o    (m_vec)
   );

   logic [DW-1:0] merged;
   stb_byte_merge #(.BW(BW)) u_merge (
      .old_data(data_q[m_idx]),
      .new_data(st_data),
      .new_be  (st_be),
      .merged  (merged)
   );

   stb_route_e st_rt;
   stb_route_sel #(.LINEFILL_EN(LINEFILL_EN)) u_route (
      .cacheable(st_cacheable),
      .wr_alloc (st_wr_alloc),
      .hit      (st_hit),
      .route    (st_rt)
   );

   logic accept, do_merge, do_alloc;
   assign st_ready = m_hit || !full;
   assign accept   = st_valid && st_ready;
   assign do_merge = accept && m_hit;
   assign do_alloc = accept && !m_hit;

   // control state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
         valid_q <= '0;
         open_q  <= '0;
      end else begin
         if (fire)     head_q <= head_q + 1'b1;
         if (do_alloc) tail_q <= tail_q + 1'b1;
         count_q <= count_q + CW'(do_alloc) - CW'(fire);
         for (int i = 0; i < DEPTH; i++) begin
            if (fire && head_q == PW'(i)) begin
               valid_q[i] <= 1'b0;
               open_q[i]  <= 1'b0;
            end
            if (drain) open_q[i] <= 1'b0;
            if (do_alloc && tail_q == PW'(i)) begin
               valid_q[i] <= 1'b1;
               open_q[i]  <= !drain;
            end
         end
      end
   end

   // payload
   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (do_alloc && tail_q == PW'(i)) begin
            tag_q[i]   <= st_tag;
            data_q[i]  <= st_data;
            be_q[i]    <= st_be;
            route_q[i] <= st_rt;
         end else if (do_merge && m_idx == PW'(i)) begin
            data_q[i]  <= merged;
            be_q[i]    <= be_q[i] | st_be;
         end
      end
   end

   // assertions
   p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ram_req, lf_req, axi_req}));

   p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((ram_req || lf_req || axi_req) && !fire) |=>
         ($stable(out_addr) && $stable({ram_req, lf_req, axi_req})));

   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= CW'(DEPTH));

   p_drain_closes_r10: assert property (@(posedge clk) disable iff (!rst_n)
      drain |=> (open_q == '0));

   p_drained_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      drained |-> !(ram_req || lf_req || axi_req));
endmodule

// File: tb/tb_stb_merge_buf.sv
`timescale 1ns/1ps
module tb_stb_merge_buf;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        st_valid = 1'b0, st_ready;
   logic [31:0] st_addr = '0;
   logic [63:0] st_data = '0;
   logic [7:0]  st_be = '0;
   logic        st_cacheable = 1'b0, st_wr_alloc = 1'b0, st_hit = 1'b0;
   logic        drain = 1'b0, drained;
   logic        ram_req, lf_req, axi_req;
   logic        ram_gnt = 1'b0, lf_gnt = 1'b0, axi_gnt = 1'b0;
   logic [28:0] out_addr;
   logic [63:0] out_data;
   logic [7:0]  out_be;

   always #5 clk = ~clk;

   stb_merge_buf dut (
      .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
      .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
      .st_cacheable(st_cacheable), .st_wr_alloc(st_wr_alloc), .st_hit(st_hit),
      .drain(drain), .drained(drained),
      .ram_req(ram_req), .ram_gnt(ram_gnt), .lf_req(lf_req), .lf_gnt(lf_gnt),
      .axi_req(axi_req), .axi_gnt(axi_gnt),
      .out_addr(out_addr), .out_data(out_data), .out_be(out_be)
   );

   typedef struct {
      logic [1:0]  rt;
      logic [28:0] tag;
      logic [63:0] data;
      logic [7:0]  be;
      bit          open;
   } item_t;

   item_t       exp_q[$];
   int          n_chk = 0, n_fail = 0;
   bit          stall = 1'b1;
   bit          fire_now = 1'b0;
   bit          done = 1'b0;
   logic [31:0] lcg = 32'h1234_5678;

   function automatic logic [1:0] route_of(input bit c, input bit wa, input bit h);
      if (c && h)       return 2'd0;  // cache RAM write
      else if (c && wa) return 2'd1;  // linefill
      else              return 2'd2;  // AXI write
   endfunction

   function automatic logic [63:0] lane_merge(input logic [63:0] o, input logic [63:0] n,
                                              input logic [7:0] be);
      logic [63:0] r;
      for (int k = 0; k < 8; k++) r[8*k +: 8] = be[k] ? n[8*k +: 8] : o[8*k +: 8];
      return r;
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   // monitor: grant policy, then compare the handshake due at the next edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         lcg = lcg * 32'd1664525 + 32'd1013904223;
         ram_gnt = ram_req && !stall && lcg[20];
         lf_gnt  = lf_req  && !stall && lcg[21];
         axi_gnt = axi_req && !stall && lcg[22];
         fire_now = (ram_req && ram_gnt) || (lf_req && lf_gnt) || (axi_req && axi_gnt);
         if (fire_now) begin
            logic [1:0] rt;
            rt = ram_req ? 2'd0 : (lf_req ? 2'd1 : 2'd2);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected transaction", {35'd0, out_addr}, 64'd0);
            end else begin
               item_t e;
               e = exp_q.pop_front();
               // R4 R5 R6 route, R7 order, R3 merged payload
               chk(rt == e.rt, "R4/R5/R6 route", 64'(rt), 64'(e.rt));
               chk(out_addr == e.tag, "R7 order/address", 64'(out_addr), 64'(e.tag));
               chk(out_data == e.data && out_be == e.be, "R3 merged data",
                   out_data, e.data);
            end
         end
      end else begin
         fire_now = 1'b0;
      end
   end

   task automatic put(input logic [31:0] a, input logic [63:0] d, input logic [7:0] be,
                      input bit c, input bit wa, input bit h);
      int  idx;
      bit  exp_rdy;
      @(negedge clk); #1;
      st_addr = a; st_data = d; st_be = be;
      st_cacheable = c; st_wr_alloc = wa; st_hit = h; st_valid = 1'b1;
      #1;
      idx = -1;
      foreach (exp_q[i]) if (exp_q[i].open && exp_q[i].tag == a[31:3]) idx = i;
      exp_rdy = (idx >= 0) || ((exp_q.size() + int'(fire_now)) < 4);
      chk(st_ready == exp_rdy, "R9 ready", 64'(st_ready), 64'(exp_rdy));
      if (exp_rdy) begin
         if (idx >= 0) begin
            exp_q[idx].data = lane_merge(exp_q[idx].data, d, be);
            exp_q[idx].be   = exp_q[idx].be | be;
         end else begin
            item_t n;
            n.rt = route_of(c, wa, h); n.tag = a[31:3]; n.data = d; n.be = be; n.open = 1'b1;
            exp_q.push_back(n);
         end
      end
      @(posedge clk); #1;
      st_valid = 1'b0;
   endtask

   task automatic drain_pulse();
      @(negedge clk); #1;
      drain = 1'b1;
      foreach (exp_q[i]) exp_q[i].open = 1'b0;
      @(posedge clk); #1;
      drain = 1'b0;
   endtask

   task automatic wait_empty();
      int t;
      t = 0;
      while ((exp_q.size() != 0 || !drained) && t < 2000) begin
         @(negedge clk); t++;
      end
      #2;
      chk(drained == 1'b1 && exp_q.size() == 0, "R11 drained after emptying",
          64'(drained), 64'd1);
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk); #2;
      // R1 reset state
      chk(drained == 1'b1, "R1 drained", 64'(drained), 64'd1);
      chk(st_ready == 1'b1, "R1 ready", 64'(st_ready), 64'd1);
      chk({ram_req, lf_req, axi_req} == 3'b000, "R1 no request",
          64'({ram_req, lf_req, axi_req}), 64'd0);

      // R3 merge into one cacheable-hit entry (R4)
      put(32'h0000_0100, 64'h1111_1111_AAAA_BBBB, 8'h0F, 1, 0, 1);
      put(32'h0000_0104, 64'h2222_3333_0000_0000, 8'hF0, 1, 0, 0);
      put(32'h0000_0101, 64'h0000_0000_0000_CC00, 8'h02, 0, 0, 0);
      @(negedge clk); #2;
      chk(drained == 1'b0, "R11 not drained with entry", 64'(drained), 64'd0);
      chk(ram_req && !lf_req && !axi_req, "R4 ram route raised",
          64'({ram_req, lf_req, axi_req}), 64'b100);
      // R8 held while not granted
      @(negedge clk); #2;
      chk(ram_req && out_addr == 29'h20, "R8 request held", 64'(out_addr), 64'h20);

      // R5, R6 routes; fill all four entries
      put(32'h0000_0200, 64'h0123_4567_89AB_CDEF, 8'hFF, 1, 1, 0);
      put(32'h0000_0300, 64'h0000_0000_0000_0055, 8'h01, 0, 1, 1);
      put(32'h0000_0400, 64'h9900_0000_0000_0000, 8'h80, 1, 0, 0);
      // R9 full, new doubleword rejected
      put(32'h0000_0500, 64'hDEAD_BEEF_DEAD_BEEF, 8'hFF, 1, 0, 1);
      // R9 full, merge still accepted
      put(32'h0000_0302, 64'h0000_0000_0077_0000, 8'h04, 1, 0, 1);

      // R2 garbage with valid low must not create entries
      @(negedge clk); #1;
      st_addr = 32'h0000_0600; st_data = '1; st_be = 8'hFF; st_cacheable = 1'b1;
      stall = 1'b0;
      repeat (3) @(negedge clk);
      st_addr = 32'h0000_0208; st_be = 8'h0F;
      wait_empty();
      repeat (5) @(negedge clk);
      #2;
      chk({ram_req, lf_req, axi_req} == 3'b000 && drained, "R2 no phantom entry",
          64'({ram_req, lf_req, axi_req}), 64'd0);

      // R10 drain closes entry; same doubleword becomes a second transaction
      stall = 1'b1;
      put(32'h0000_0700, 64'h0000_0000_0000_00A1, 8'h01, 0, 0, 0);
      drain_pulse();
      put(32'h0000_0700, 64'h0000_0000_0000_B200, 8'h02, 0, 0, 0);
      #1;
      chk(exp_q.size() == 2, "R10 separate entries in model", 64'(exp_q.size()), 64'd2);
      stall = 1'b0;
      wait_empty();

      // mixed traffic with random grants
      for (int it = 0; it < 150; it++) begin
         logic [31:0] r;
         lcg = lcg * 32'd1103515245 + 32'd12345;
         r = lcg;
         if (r[27:24] == 4'hF) drain_pulse();
         put({23'd0, 3'(r[2:0] % 6), 3'd0, r[5:3]} | 32'h0000_1000,
             {r, ~r}, (r[15:8] == 8'd0) ? 8'h01 : r[15:8], r[16], r[17], r[18]);
      end
      wait_empty();

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule